// File: doc/BRIEF.md
# Multiplier Access Hazard Interlock

This block decides when a five-stage in-order pipeline must hold because of its shared multiply unit. It looks only at the instruction sitting in the memory-access (MA) stage. That instruction might be a multiply, a multiply-accumulate or a read of the high/low accumulator pair. If the multiplier is still working on an earlier result, the block raises a stall.

The stall freezes the front four stage registers and sends a bubble into writeback. After a multiplier-class instruction finishes its MA stage, a countdown holds the multiplier busy. It stays busy for two cycles for a single-length (32-bit result) operation and for four cycles for a double-length (64-bit result) one. The countdown keeps running while the pipeline is held.

A multiply-accumulate spends two cycles in MA. The first cycle always holds the pipeline. Only the second cycle checks whether the multiplier is busy and starts it.

Top module: `mul_hazard_top`

## Requirements
- R1: A synchronous active-high reset clears the busy countdown and the multiply-accumulate phase. After reset, `mulBusy` is 0 and `stall` is 0 for an idle MA stage.
- R2: A single-length (`maLong`=0) multiplier-class instruction that leaves MA makes `mulBusy` high for exactly the next 2 cycles.
- R3: A double-length (`maLong`=1) multiplier-class instruction that leaves MA makes `mulBusy` high for exactly the next 4 cycles.
- R4: A valid accumulator-to-register move (`maClass`=3) in MA raises `stall` in every cycle that `mulBusy` is high. It does not stall once `mulBusy` is low.
- R5: A valid accumulator-to-memory store (`maClass`=4) follows the same rule as R4.
- R6: A valid plain multiply (`maClass`=1) in MA stalls while `mulBusy` is high. It starts the multiplier in the first cycle that `mulBusy` is low.
- R7: A valid multiply-accumulate (`maClass`=2) stalls on its first MA cycle whatever the multiplier state. On its second MA cycle it stalls while `mulBusy` is high and otherwise starts the multiplier without stalling.
- R8: A valid instruction of any other class (`maClass`=0, 5, 6, 7) never stalls, even while the multiplier is busy.
- R9: The busy countdown decrements in every cycle, including stalled cycles. A waiting accumulator access is therefore released exactly when the countdown reaches zero.
- R10: With `maValid` low, `stall` is 0 and the multiplier is not started, whatever `maClass` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| maValid | input | 1 | MA stage holds a valid instruction |
| maClass | input | 3 | Class of the MA instruction (0 other, 1 multiply, 2 multiply-accumulate, 3 accumulator to register, 4 accumulator to memory) |
| maLong | input | 1 | Multiplier result is double length |
| stall | output | 1 | Hold IF/ID/EX/MA and send a bubble to WB |
| mulBusy | output | 1 | Multiplier countdown is non-zero |

## Verification
Two things can land in the same cycle: the countdown reaching zero, and a waiting instruction deciding whether it may proceed. A waiting accumulator access or multiply-accumulate second phase must be released in exactly the cycle `mulBusy` drops. A new multiply issued in that cycle must reload the countdown rather than let it stay at zero.

Directed sequences put an accumulator access, a multiply and a multiply-accumulate right behind a busy multiplier. Constrained random streams then repeat those back-to-back cases many times. Every cycle, `stall` and `mulBusy` are compared against a bench model that counts down from the requirement values.

// File: rtl/mul_hazard_pkg.sv
package mul_hazard_pkg;
  typedef enum logic [2:0] {
    CLS_OTHER   = 3'd0,
    CLS_MUL     = 3'd1,
    CLS_MAC     = 3'd2,
    CLS_ACC_REG = 3'd3,
    CLS_ACC_MEM = 3'd4
  } instClass_e;

  typedef struct packed {
    logic start;   // multiplier begins after this MA cycle
    logic isLong;  // double-length occupancy
  } mulStrobe_t;
endpackage

// File: rtl/mul_hazard_ctrl.sv
module mul_hazard_ctrl
  import mul_hazard_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       maValid,
  input  logic [2:0] maClass,
  input  logic       maLong,
  input  logic       busy,
  output logic       stall,
  output mulStrobe_t strobe
);
  logic secondPhase;

  always_comb begin
    stall         = 1'b0;
    strobe.start  = 1'b0;
    strobe.isLong = maLong;
    if (maValid) begin
      case (maClass)
        CLS_MUL: begin
          if (busy) stall = 1'b1;
          else strobe.start = 1'b1;
        end
        CLS_MAC: begin
          if (!secondPhase) stall = 1'b1;
          else if (busy) stall = 1'b1;
          else strobe.start = 1'b1;
        end
        CLS_ACC_REG, CLS_ACC_MEM: stall = busy;
        default: stall = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) secondPhase <= 1'b0;
    else if (maValid && maClass == CLS_MAC && !secondPhase) secondPhase <= 1'b1;
    else if (strobe.start || !(maValid && maClass == CLS_MAC)) secondPhase <= 1'b0;
  end
endmodule

// File: rtl/mul_hazard_dp.sv
module mul_hazard_dp
  import mul_hazard_pkg::*;
#(
  parameter int SHORT_CYC = 2,
  parameter int LONG_CYC  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  mulStrobe_t strobe,
  output logic       busy
);
  localparam int CntW = $clog2(LONG_CYC + 1);
  localparam logic [CntW-1:0] ShortVal = CntW'(SHORT_CYC);
  localparam logic [CntW-1:0] LongVal  = CntW'(LONG_CYC);

  logic [CntW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) remain <= '0;
    else if (strobe.start) remain <= strobe.isLong ? LongVal : ShortVal;
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/mul_hazard_top.sv
module mul_hazard_top #(
  parameter int SHORT_CYC = 2,
  parameter int LONG_CYC  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       maValid,
  input  logic [2:0] maClass,
  input  logic       maLong,
  output logic       stall,
  output logic       mulBusy
);
  mul_hazard_pkg::mulStrobe_t strobe;

  mul_hazard_ctrl u_ctrl (
    .clk(clk), .rst(rst), .maValid(maValid), .maClass(maClass),
    .maLong(maLong), .busy(mulBusy), .stall(stall), .strobe(strobe)
  );

  mul_hazard_dp #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .busy(mulBusy)
  );
endmodule

// File: rtl/mul_hazard_chk.sv
module mul_hazard_chk (
  input logic       clk,
  input logic       rst,
  input logic       maValid,
  input logic [2:0] maClass,
  input logic       maLong,
  input logic       stall,
  input logic       mulBusy
);
  logic isMulCls, issue, isAcc, isOther;
  assign isMulCls = (maClass == 3'd1) || (maClass == 3'd2);
  assign issue    = maValid && isMulCls && !stall;
  assign isAcc    = (maClass == 3'd3) || (maClass == 3'd4);
  assign isOther  = !isMulCls && !isAcc;

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !mulBusy); // R1
  AST_SHORT_OCC: assert property (@(posedge clk) disable iff (rst)
    issue && !maLong |=> mulBusy ##1 mulBusy ##1 !mulBusy); // R2
  AST_LONG_OCC: assert property (@(posedge clk) disable iff (rst)
    issue && maLong |=> mulBusy ##1 mulBusy ##1 mulBusy ##1 mulBusy ##1 !mulBusy); // R3
  AST_ACC_WAIT: assert property (@(posedge clk) disable iff (rst)
    maValid && isAcc |-> stall == mulBusy); // R4
  AST_MUL_WAIT: assert property (@(posedge clk) disable iff (rst)
    maValid && maClass == 3'd1 |-> stall == mulBusy); // R6
  AST_MAC_TWO_MA: assert property (@(posedge clk) disable iff (rst)
    maValid && maClass == 3'd2 && !stall |-> $past(stall && maValid && maClass == 3'd2)); // R7
  AST_OTHER_FREE: assert property (@(posedge clk) disable iff (rst)
    maValid && isOther |-> !stall); // R8
  AST_INVALID_FREE: assert property (@(posedge clk) disable iff (rst)
    !maValid |-> !stall); // R10
endmodule

bind mul_hazard_top mul_hazard_chk u_chk (
  .clk(clk), .rst(rst), .maValid(maValid), .maClass(maClass),
  .maLong(maLong), .stall(stall), .mulBusy(mulBusy)
);

// File: tb/sim_mul_hazard_top.sv
module sim_mul_hazard_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic maValid = 1'b0;
  logic [2:0] maClass = 3'd0;
  logic maLong = 1'b0;
  logic stall, mulBusy;

  int checks = 0;
  int fails = 0;
  int mCnt = 0;      // model countdown
  bit mSec = 1'b0;   // model multiply-accumulate second phase
  bit done = 1'b0;

  always #2 clk = ~clk;

  mul_hazard_top u0 (
    .clk(clk), .rst(rst), .maValid(maValid), .maClass(maClass),
    .maLong(maLong), .stall(stall), .mulBusy(mulBusy)
  );

  // expected stall from the requirements (R4..R8, R10)
  function automatic bit expStall(bit v, logic [2:0] c);
    if (!v) return 1'b0;
    case (c)
      3'd1: return mCnt != 0;
      3'd2: return !mSec || (mCnt != 0);
      3'd3, 3'd4: return mCnt != 0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string stallTag(bit v, logic [2:0] c);
    if (!v) return "R10";
    case (c)
      3'd1: return "R6";
      3'd2: return "R7";
      3'd3: return "R4/R9";
      3'd4: return "R5/R9";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // one cycle: drive, check, advance model; returns the stall seen
  task automatic step(bit v, logic [2:0] c, bit l, output bit st);
    bit es, start;
    @(negedge clk);
    maValid = v; maClass = c; maLong = l;
    #1;
    es = expStall(v, c);
    check(stallTag(v, c), stall, es);
    check(l ? "R3" : "R2", mulBusy, mCnt != 0);
    start = v && (c == 3'd1 || c == 3'd2) && !es;
    st = stall;
    @(posedge clk);
    if (v && c == 3'd2 && !mSec) mSec = 1'b1;
    else if (start || !(v && c == 3'd2)) mSec = 1'b0;
    if (start) mCnt = l ? 4 : 2;
    else if (mCnt != 0) mCnt--;
  endtask

  // hold an instruction in MA until it is no longer stalled
  task automatic issueInstr(bit v, logic [2:0] c, bit l);
    bit st;
    do step(v, c, l, st); while (st);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finishRun();
    end
  end

  initial begin
    int stallRun;
    bit st;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1", mulBusy, 1'b0);
    check("R1", stall, 1'b0);

    // R3 + R4 + R9: long multiply then accumulator read waits 4 cycles
    issueInstr(1, 3'd1, 1);
    stallRun = 0;
    do begin step(1, 3'd3, 0, st); if (st) stallRun++; end while (st);
    check("R3/R4 stall count", stallRun == 4, 1'b1);

    // R2 + R5: short multiply then accumulator store waits 2 cycles
    issueInstr(1, 3'd1, 0);
    stallRun = 0;
    do begin step(1, 3'd4, 0, st); if (st) stallRun++; end while (st);
    check("R2/R5 stall count", stallRun == 2, 1'b1);

    // R7: back-to-back multiply-accumulates, R8/R10 while busy
    issueInstr(1, 3'd2, 1);
    step(1, 3'd0, 0, st);
    step(0, 3'd3, 0, st);
    step(1, 3'd6, 0, st);
    issueInstr(1, 3'd2, 0);
    issueInstr(1, 3'd1, 1);
    issueInstr(1, 3'd3, 0);

    // R1: reset mid-operation
    issueInstr(1, 3'd1, 1);
    @(negedge clk);
    rst = 1'b1; maValid = 1'b0;
    @(posedge clk);
    mCnt = 0; mSec = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1", mulBusy, 1'b0);

    // constrained random stream, multiplier-heavy mix
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 9);
      logic [2:0] c = (r < 3) ? 3'd1 : (r < 5) ? 3'd2 : (r < 7) ? 3'(3 + (r & 1)) : 3'($urandom_range(0, 7));
      issueInstr($urandom_range(0, 7) != 0, c, $urandom_range(0, 1) == 1);
    end

    done = 1'b1;
    finishRun();
  end
endmodule